// File: doc/BRIEF.md
# Flash Segment Command Register

This block is the command register and mode controller for one memory segment of a flash store. The host drives an asynchronous write interface: an active-low write strobe, an address bus and a byte-wide data bus. A free-running system clock samples that interface. The block reads a command byte from each completed write strobe. It then decides what the segment returns on its read data output. That output is either the contents of the memory array or the identification codes of the part.

The address bus is split into two parts. The upper bits select a segment and the lower bits are the offset inside it. The block accepts a command only when the address held at the start of the write strobe points at its own segment. Two indicators can stop command writes: a supply-lockout input and a write-protect input. Supply lockout also sends the controller back to array reads. The memory array here is a behavioural stand-in. Each byte it returns is computed from the offset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode: `id_mode` is 0 and reads return array data with no command written first.
- R2: In array-read mode, `rd_data` equals the XOR fold of the offset `addr[15:0]`, bit i going to bit i mod 8, XORed with 0x5A.
- R3: The segment field `addr[17:16]` is taken at the falling edge of `we_n`. A write is accepted only if that field equals SEG_ID (default 1), whatever the field holds at the rising edge.
- R4: The command byte is taken from `din` at the rising edge of `we_n`, not at the falling edge. An accepted command takes effect by the fourth clock edge after `we_n` rises.
- R5: Writing 0x90 enters identification mode, and `id_mode` goes to 1.
- R6: In identification mode, offset 0x0000 reads the manufacturer code (default 0x01), offset 0x0002 reads the device code (default 0xA4), and every other offset reads 0x00.
- R7: Writing 0xF0 returns the controller to array-read mode. It is the only command that leaves identification mode.
- R8: A command byte other than 0x90 or 0xF0 leaves the mode unchanged.
- R9: While `lockout` is 1, the controller is held in array-read mode and every write is ignored. Asserting it during identification mode returns the controller to array reads.
- R10: While `wprot` is 1, command writes are ignored and the mode stays as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the write interface |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Asynchronous active-low write strobe |
| addr | input | 18 | Segment select (bits 17:16) and offset (bits 15:0) |
| din | input | 8 | Command byte bus |
| lockout | input | 1 | Supply-lockout indicator, active high |
| wprot | input | 1 | Write-protect indicator, active high |
| rd_data | output | 8 | Byte returned for the current offset |
| id_mode | output | 1 | 1 while identification mode is active |

## Verification
The hardest cases to reach are the ones where the bus changes during a write strobe. One is a segment address that is valid at the falling edge but points elsewhere by the rising edge. Another is a command byte that changes between the two edges. A third is lockout arriving while identification mode is active. The bench's write task takes separate address and data values for each edge of the strobe, so it can build all of these on purpose. It raises lockout only after identification mode has been confirmed through an identification read.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command values for the flash segment command register.
// Assumes byte-wide commands; one bit of mode state.
package flash_cmd_pkg;
    typedef enum logic {
        MODE_READ = 1'b0,
        MODE_ID   = 1'b1
    } mode_t;

    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_RESET = 8'hF0;
endpackage

// File: rtl/fcr_we_sync.sv
// Brings the asynchronous write strobe into the clock domain through two
// flops, then detects its edges with a third delayed copy.
// Assumes each strobe level lasts at least two clock periods.
module fcr_we_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic fall_p,
    output logic rise_p
);
    logic s1, s2, s3;

    // synchronizer chain plus delayed copy; idle level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= we_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // one-cycle pulses at each synchronized edge
    always_comb begin
        fall_p = s3 & ~s2;
        rise_p = ~s3 & s2;
    end
endmodule

// File: rtl/fcr_capture.sv
// Takes the segment field on the falling strobe edge and the command byte
// on the rising edge, then presents them together with a one-cycle strobe.
// Assumes addr and din are stable around the synchronized edges.
module fcr_capture #(
    parameter int SEG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_p,
    input  logic             rise_p,
    input  logic [SEG_W-1:0] addr_seg,
    input  logic [7:0]       din,
    output logic             cmd_stb,
    output logic [SEG_W-1:0] cmd_seg,
    output logic [7:0]       cmd_data
);
    logic [SEG_W-1:0] seg_q;
    logic             armed;

    // hold the segment from the falling edge until the matching rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q    <= '0;
            armed    <= 1'b0;
            cmd_stb  <= 1'b0;
            cmd_seg  <= '0;
            cmd_data <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (fall_p) begin
                seg_q <= addr_seg;
                armed <= 1'b1;
            end else if (rise_p && armed) begin
                armed    <= 1'b0;
                cmd_stb  <= 1'b1;
                cmd_seg  <= seg_q;
                cmd_data <= din;
            end
        end
    end

    // R4
    stb_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(rise_p));
endmodule

// File: rtl/fcr_mode_fsm.sv
// Mode state machine: decodes captured commands for this segment and holds
// read or identification mode. Lockout overrides everything.
// Assumes at most one command strobe per cycle.
module fcr_mode_fsm
    import flash_cmd_pkg::*;
#(
    parameter int              SEG_W  = 2,
    parameter logic [SEG_W-1:0] SEG_ID = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic [SEG_W-1:0] cmd_seg,
    input  logic [7:0]       cmd_data,
    input  logic             lockout,
    input  logic             wprot,
    output mode_t            mode
);
    logic accept;

    // a command counts only for this segment with both guards clear
    always_comb accept = cmd_stb && (cmd_seg == SEG_ID) && !lockout && !wprot;

    // mode register with lockout forcing array reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_READ;
        end else if (lockout) begin
            mode <= MODE_READ;
        end else if (accept) begin
            case (cmd_data)
                CMD_IDENT: mode <= MODE_ID;
                CMD_RESET: mode <= MODE_READ;
                default:   mode <= mode;
            endcase
        end
    end

    // R9
    lockout_forces_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> mode == MODE_READ);

    // R10
    protect_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wprot && !lockout) |=> $stable(mode));
endmodule

// File: rtl/fcr_read_mux.sv
// Chooses the read byte: array model data or identification codes.
// The array model folds the offset bits into a byte and XORs a constant.
module fcr_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int         OFF_W    = 16,
    parameter logic [7:0] MFR_CODE = 8'h01,
    parameter logic [7:0] DEV_CODE = 8'hA4
) (
    input  mode_t            mode,
    input  logic [OFF_W-1:0] offset,
    output logic [7:0]       rd_data
);
    localparam logic [7:0] ARRAY_SEED = 8'h5A;

    logic [7:0] array_byte;

    // behavioural array: bit i of the offset lands on bit i mod 8
    always_comb begin
        array_byte = ARRAY_SEED;
        for (int i = 0; i < OFF_W; i++) begin
            array_byte[i % 8] = array_byte[i % 8] ^ offset[i];
        end
    end

    // output select by mode and offset
    always_comb begin
        if (mode == MODE_ID) begin
            if (offset == OFF_W'(0))      rd_data = MFR_CODE;
            else if (offset == OFF_W'(2)) rd_data = DEV_CODE;
            else                          rd_data = 8'h00;
        end else begin
            rd_data = array_byte;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the segment command register: strobe synchronizer, edge capture,
// mode state machine and read select.
// Assumes the address's upper SEG_W bits choose the segment.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int               AW       = 18,
    parameter int               SEG_W    = 2,
    parameter logic [SEG_W-1:0] SEG_ID   = 1,
    parameter logic [7:0]       MFR_CODE = 8'h01,
    parameter logic [7:0]       DEV_CODE = 8'hA4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          lockout,
    input  logic          wprot,
    output logic [7:0]    rd_data,
    output logic          id_mode
);
    localparam int OFF_W = AW - SEG_W;

    logic             fall_p, rise_p, cmd_stb;
    logic [SEG_W-1:0] cmd_seg;
    logic [7:0]       cmd_data;
    mode_t            mode;

    fcr_we_sync u_sync (
        .clk(clk), .rst_n(rst_n), .we_n(we_n),
        .fall_p(fall_p), .rise_p(rise_p)
    );

    fcr_capture #(.SEG_W(SEG_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fall_p(fall_p), .rise_p(rise_p),
        .addr_seg(addr[AW-1 -: SEG_W]), .din(din),
        .cmd_stb(cmd_stb), .cmd_seg(cmd_seg), .cmd_data(cmd_data)
    );

    fcr_mode_fsm #(.SEG_W(SEG_W), .SEG_ID(SEG_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_seg(cmd_seg),
        .cmd_data(cmd_data), .lockout(lockout), .wprot(wprot), .mode(mode)
    );

    fcr_read_mux #(.OFF_W(OFF_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
        .mode(mode), .offset(addr[OFF_W-1:0]), .rd_data(rd_data)
    );

    // expose the mode as a flag
    always_comb id_mode = (mode == MODE_ID);

    // R5
    id_entry_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(cmd_stb));

    // R7
    id_exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> ($past(cmd_stb) || $past(lockout)));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
// Directed bench for flash_cmd_ctrl; one task per scenario.
module sim_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic        lockout = 1'b0;
    logic        wprot = 1'b0;
    logic [7:0]  rd_data;
    logic        id_mode;

    int checks = 0;
    int errors = 0;

    flash_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
        .lockout(lockout), .wprot(wprot), .rd_data(rd_data), .id_mode(id_mode)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] arr_exp(input logic [15:0] off);
        logic [7:0] v = 8'h5A;
        for (int i = 0; i < 16; i++) v[i % 8] = v[i % 8] ^ off[i];
        return v;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full strobe with separate bus values at each edge
    task automatic wr(input logic [17:0] a_f, input logic [7:0] d_f,
                      input logic [17:0] a_r, input logic [7:0] d_r);
        @(negedge clk);
        addr = a_f; din = d_f;
        cyc(1); we_n = 1'b0;
        cyc(4);
        addr = a_r; din = d_r;
        cyc(1); we_n = 1'b1;
        cyc(6);
    endtask

    task automatic wr_cmd(input logic [7:0] c);
        wr(18'h10000, c, 18'h10000, c);
    endtask

    task automatic rd(input logic [15:0] off, output logic [7:0] v);
        addr = {2'b01, off};
        #1 v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 id_mode", {7'b0, id_mode}, 8'h00);
        rd(16'h0000, v); check("R1 read offset 0", v, arr_exp(16'h0000));
    endtask

    task automatic t_array;
        logic [7:0] v;
        rd(16'h1234, v); check("R2 array 1234", v, arr_exp(16'h1234));
        rd(16'hFFFF, v); check("R2 array FFFF", v, arr_exp(16'hFFFF));
        rd(16'h0002, v); check("R2 array 0002", v, arr_exp(16'h0002));
    endtask

    task automatic t_ident;
        logic [7:0] v;
        wr_cmd(8'h90);
        check("R5 enter id", {7'b0, id_mode}, 8'h01);
        rd(16'h0000, v); check("R6 manufacturer", v, 8'h01);
        rd(16'h0002, v); check("R6 device", v, 8'hA4);
        rd(16'h0001, v); check("R6 other offset", v, 8'h00);
        rd(16'h8000, v); check("R6 high offset", v, 8'h00);
    endtask

    task automatic t_unknown;
        logic [7:0] v;
        wr_cmd(8'h55);
        check("R8 unknown keeps id", {7'b0, id_mode}, 8'h01);
        wr_cmd(8'h90);
        check("R8 repeat id keeps id", {7'b0, id_mode}, 8'h01);
        wr_cmd(8'hF0);
        check("R7 exit id", {7'b0, id_mode}, 8'h00);
        rd(16'h0002, v); check("R7 array after exit", v, arr_exp(16'h0002));
        wr_cmd(8'h00);
        check("R8 unknown keeps read", {7'b0, id_mode}, 8'h00);
    endtask

    task automatic t_edges;
        // segment right at fall, wrong at rise: accepted
        wr(18'h10000, 8'h90, 18'h20000, 8'h90);
        check("R3 fall address accepted", {7'b0, id_mode}, 8'h01);
        // segment wrong at fall, right at rise: ignored
        wr(18'h30000, 8'hF0, 18'h10000, 8'hF0);
        check("R3 fall address rejected", {7'b0, id_mode}, 8'h01);
        // data differs between edges: rising-edge byte wins
        wr(18'h10000, 8'h55, 18'h10000, 8'hF0);
        check("R4 data at rise", {7'b0, id_mode}, 8'h00);
        wr(18'h10000, 8'h90, 18'h10000, 8'h55);
        check("R4 fall data ignored", {7'b0, id_mode}, 8'h00);
    endtask

    task automatic t_protect;
        wprot = 1'b1;
        wr_cmd(8'h90);
        check("R10 protect blocks entry", {7'b0, id_mode}, 8'h00);
        wprot = 1'b0;
        wr_cmd(8'h90);
        check("R10 entry after release", {7'b0, id_mode}, 8'h01);
        wprot = 1'b1;
        wr_cmd(8'hF0);
        check("R10 protect blocks exit", {7'b0, id_mode}, 8'h01);
        wprot = 1'b0;
    endtask

    task automatic t_lockout;
        logic [7:0] v;
        rd(16'h0002, v); check("R9 pre-lockout id read", v, 8'hA4);
        @(negedge clk); lockout = 1'b1;
        cyc(2);
        check("R9 lockout forces read", {7'b0, id_mode}, 8'h00);
        rd(16'h0002, v); check("R9 array under lockout", v, arr_exp(16'h0002));
        wr_cmd(8'h90);
        check("R9 write ignored under lockout", {7'b0, id_mode}, 8'h00);
        lockout = 1'b0;
        cyc(2);
        check("R9 stays read after release", {7'b0, id_mode}, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_array();
        t_ident();
        t_unknown();
        t_edges();
        wr_cmd(8'hF0);
        t_protect();
        t_lockout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule